// File: doc/BRIEF.md
# ATAPI PIO Read Sequencer

This block is the device side of a packet command carried over a parallel-ATA style register file, for the case where the data phase runs in programmed I/O. The host programs a byte-count limit and issues the packet command. It then writes a 12-byte command packet through the 16-bit data register. When the packet holds a READ(10) request, the block streams the requested 2048-byte logical blocks back through the same data register.

The stream is cut into bursts. No burst is larger than the host's limit, and an odd limit is trimmed down to an even byte count. Each burst opens with an interrupt and a status word that shows the data request. After the last word the block raises one more interrupt to mark completion. The data content comes from a built-in deterministic pattern, so the block needs no storage model and a host can check every word.

A limit that is too small, a request for a DMA data phase, or any packet opcode other than READ(10) ends the command with the error bit set.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, status (register 7) reads 0x0040 and `irq` is low. The status bits are: bit 7 busy, bit 6 ready (always 1), bit 3 data request, bit 0 error; all other bits read 0.
- R2: Writing 0xA0 to register 7 while idle, with a limit of at least 2 and feature bit 0 clear, makes status read 0x0048 with no interrupt. Any other value written to register 7 leaves status and `irq` unchanged.
- R3: The packet is six writes to register 0, each carrying packet bytes 2i (low half) and 2i+1 (high half). Byte 0 is the opcode. Bytes 2..5 hold the block address, most significant byte first. Bytes 7..8 hold the block count, most significant byte first.
- R4: Before every burst, `irq` rises and status reads 0x0048.
- R5: The limit is {register 5, register 4}, captured when the command is issued. Each burst carries min(remaining bytes, limit with bit 0 cleared) bytes. Between two bursts, status reads 0x00C0 (busy, no data request).
- R6: Each block is 1024 words, and a read of count N returns N*1024 words. Word w of block b (where b = address + block offset) reads as {b[5:0], w[9:0]}.
- R7: After the last data word, `irq` rises and status reads 0x0040.
- R8: Reading register 7 clears a pending interrupt.
- R9: A limit below 2 ends the command right after it is issued: `irq` rises and status reads 0x0041.
- R10: A packet opcode other than 0x28 ends the command after the sixth packet word: `irq` rises and status reads 0x0041.
- R11: Feature register (register 1) bit 0 set when the command is issued ends the command at once: `irq` rises and status reads 0x0041.
- R12: A block count of zero completes after the packet with no data phase: `irq` rises and status reads 0x0040.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe; reads of data and status have side effects |
| host_addr | input | 3 | Register select (0 data, 1 feature, 4 limit low, 5 limit high, 7 command/status) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check four things: busy and data request are never shown together, an error never coexists with a data request, a burst count never exceeds the captured limit, and each data read removes exactly one word from the remaining total. They also check that a status read in the data phase drops the interrupt, and that foreign command codes leave the sequencer idle. Only the scenarios can show the rest: the decoding of the packet fields, the exact split into bursts for even, odd and non-dividing limits, the pattern value of every word (including the wrap of the block field), and the distinct error and zero-count endings.

// File: rtl/atapi_seq_pkg.sv
// Shared encodings for the packet read sequencer.
// Assumes a register file with 3-bit addresses and 8-bit command codes.
package atapi_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PKT  = 2'd1,
        ST_PREP = 2'd2,
        ST_XFER = 2'd3
    } seq_state_t;

    localparam logic [7:0] OPC_PACKET = 8'hA0;
    localparam logic [7:0] OPC_READ10 = 8'h28;

    localparam logic [2:0] RA_DATA = 3'd0;
    localparam logic [2:0] RA_FEAT = 3'd1;
    localparam logic [2:0] RA_LIML = 3'd4;
    localparam logic [2:0] RA_LIMH = 3'd5;
    localparam logic [2:0] RA_CMD  = 3'd7;
endpackage

// File: rtl/pkt_capture.sv
// Collects the command packet word by word and exposes the decoded
// READ(10) fields. Assumes PKT_WORDS >= 5 so that every field is present.
module pkt_capture #(
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic        full,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] count
);
    localparam int IDX_W = $clog2(PKT_WORDS + 1);

    logic [IDX_W-1:0] idx_q;
    logic [15:0]      pkt_q [PKT_WORDS];

    assign full = (idx_q == IDX_W'(PKT_WORDS));

    // Word pointer: restarts on a new command, advances per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (clear)            idx_q <= '0;
        else if (wr_en && !full)   idx_q <= idx_q + 1'b1;
    end

    // One holding register per packet word.
    for (genvar g = 0; g < PKT_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && !full && idx_q == IDX_W'(g)) pkt_q[g] <= wdata;
        end
    end

    // Field extraction: words are little-endian, fields big-endian.
    assign opcode = pkt_q[0][7:0];
    assign lba    = {pkt_q[1][7:0], pkt_q[1][15:8], pkt_q[2][7:0], pkt_q[2][15:8]};
    assign count  = {pkt_q[3][15:8], pkt_q[4][7:0]};

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(PKT_WORDS));
endmodule

// File: rtl/burst_sizer.sv
// Picks the next burst length in words: the smaller of the words still
// owed and the even-trimmed limit. Assumes TOT_W > 15.
module burst_sizer #(
    parameter int TOT_W = 26
) (
    input  logic [TOT_W-1:0] remain,
    input  logic [14:0]      lim_words,
    output logic [14:0]      burst
);
    // Minimum of remaining words and limit words.
    always_comb begin
        if (remain < TOT_W'(lim_words)) burst = remain[14:0];
        else                            burst = lim_words;
    end
endmodule

// File: rtl/pattern_gen.sv
// Produces the deterministic data word for a block number and word index.
// Assumes WIB_W < 16.
module pattern_gen #(
    parameter int WIB_W = 10
) (
    input  logic [31:0]      blk,
    input  logic [WIB_W-1:0] widx,
    output logic [15:0]      word
);
    assign word = {blk[15-WIB_W:0], widx};
endmodule

// File: rtl/atapi_pio_seq.sv
// Device-side sequencer for a packet command with a PIO data phase.
// Accepts a READ(10) packet and returns blocks in limit-sized bursts,
// each announced by an interrupt. Assumes BLOCK_WORDS is a power of two
// and that the host reads status before it reads each burst.
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLOCK_WORDS = 1024,
    parameter int PKT_WORDS   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_re,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq
);
    localparam int WIB_W = $clog2(BLOCK_WORDS);
    localparam int TOT_W = 16 + WIB_W;

    seq_state_t       state_q;
    logic [7:0]       feat_q, liml_q, limh_q;
    logic [14:0]      lim_words_q, burst_left_q, burst_sz;
    logic [TOT_W-1:0] total_left_q, total_calc;
    logic [31:0]      blk_q;
    logic [WIB_W-1:0] wib_q;
    logic             err_q, irq_q;
    logic             pkt_full;
    logic [7:0]       pkt_opcode;
    logic [31:0]      pkt_lba;
    logic [15:0]      pkt_count, lim_in, pat_word;
    logic             wr_cmd, wr_data, rd_data, rd_stat, cmd_go, lim_bad;
    logic             bsy, drq;

    assign wr_cmd  = host_we && host_addr == RA_CMD;
    assign wr_data = host_we && host_addr == RA_DATA;
    assign rd_data = host_re && host_addr == RA_DATA;
    assign rd_stat = host_re && host_addr == RA_CMD;
    assign cmd_go  = wr_cmd && host_wdata[7:0] == OPC_PACKET && state_q == ST_IDLE;
    assign lim_in  = {limh_q, liml_q};
    assign lim_bad = lim_in < 16'd2;
    assign total_calc = {pkt_count, {WIB_W{1'b0}}};

    pkt_capture #(.PKT_WORDS(PKT_WORDS)) pkt_i (
        .clk(clk), .rst_n(rst_n), .clear(cmd_go),
        .wr_en(wr_data && state_q == ST_PKT), .wdata(host_wdata),
        .full(pkt_full), .opcode(pkt_opcode), .lba(pkt_lba), .count(pkt_count)
    );

    burst_sizer #(.TOT_W(TOT_W)) size_i (
        .remain(total_left_q), .lim_words(lim_words_q), .burst(burst_sz)
    );

    pattern_gen #(.WIB_W(WIB_W)) pat_i (
        .blk(blk_q), .widx(wib_q), .word(pat_word)
    );

    // Host-programmed parameter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q <= '0; liml_q <= '0; limh_q <= '0;
        end else if (host_we) begin
            if (host_addr == RA_FEAT) feat_q <= host_wdata[7:0];
            if (host_addr == RA_LIML) liml_q <= host_wdata[7:0];
            if (host_addr == RA_LIMH) limh_q <= host_wdata[7:0];
        end
    end

    // Command sequencing, data position tracking and interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; err_q <= 1'b0; irq_q <= 1'b0;
            lim_words_q <= '0; total_left_q <= '0; burst_left_q <= '0;
            blk_q <= '0; wib_q <= '0;
        end else begin
            if (rd_stat) irq_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (cmd_go) begin
                    err_q       <= 1'b0;
                    lim_words_q <= lim_in[15:1];
                    if (lim_bad || feat_q[0]) begin
                        err_q <= 1'b1;
                        irq_q <= 1'b1;
                    end else begin
                        state_q <= ST_PKT;
                    end
                end
                ST_PKT: if (pkt_full) begin
                    if (pkt_opcode != OPC_READ10) begin
                        err_q   <= 1'b1;
                        irq_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (pkt_count == 16'd0) begin
                        irq_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        total_left_q <= total_calc;
                        blk_q        <= pkt_lba;
                        wib_q        <= '0;
                        state_q      <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    burst_left_q <= burst_sz;
                    irq_q        <= 1'b1;
                    state_q      <= ST_XFER;
                end
                ST_XFER: if (rd_data) begin
                    total_left_q <= total_left_q - 1'b1;
                    burst_left_q <= burst_left_q - 1'b1;
                    if (wib_q == WIB_W'(BLOCK_WORDS - 1)) begin
                        wib_q <= '0;
                        blk_q <= blk_q + 1'b1;
                    end else begin
                        wib_q <= wib_q + 1'b1;
                    end
                    if (total_left_q == TOT_W'(1)) begin
                        irq_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (burst_left_q == 15'd1) begin
                        state_q <= ST_PREP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bsy = (state_q == ST_PREP) || (state_q == ST_PKT && pkt_full);
    assign drq = (state_q == ST_XFER) || (state_q == ST_PKT && !pkt_full);
    assign irq = irq_q;

    // Read multiplexer for the host register file.
    always_comb begin
        case (host_addr)
            RA_DATA: host_rdata = (state_q == ST_XFER) ? pat_word : 16'd0;
            RA_FEAT: host_rdata = {8'd0, feat_q};
            RA_LIML: host_rdata = {8'd0, liml_q};
            RA_LIMH: host_rdata = {8'd0, limh_q};
            RA_CMD:  host_rdata = {8'd0, bsy, 1'b1, 2'b00, drq, 2'b00, err_q};
            default: host_rdata = 16'd0;
        endcase
    end

    // R1
    bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));
    // R9
    err_no_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !drq);
    // R5
    burst_le_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_XFER |-> (burst_left_q <= lim_words_q && burst_left_q != 15'd0));
    // R6
    total_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && rd_data) |=> total_left_q == $past(total_left_q) - 1'b1);
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && rd_stat) |=> !irq_q);
    // R2
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && host_wdata[7:0] != OPC_PACKET && state_q == ST_IDLE)
        |=> (state_q == ST_IDLE && $stable(err_q)));
endmodule

// File: tb/atapi_pio_seq_tb_top.sv
module atapi_pio_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    atapi_pio_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    // Look at status without the read side effect.
    task automatic peek_status(output logic [15:0] d);
        host_addr = 3'd7;
        #1 d = host_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(tag, {15'd0, irq}, 16'd1);
    endtask

    // Driver side of the scoreboard: expected words of a read.
    task automatic push_expect(input logic [31:0] lba, input int cnt);
        for (int b = 0; b < cnt; b++) begin
            logic [31:0] blk = lba + b;
            for (int w = 0; w < 1024; w++) begin
                logic [9:0] wi = w[9:0];
                exp_q.push_back({blk[5:0], wi});
            end
        end
    endtask

    // Monitor side: each data read is compared with the queue head.
    task automatic read_word();
        logic [15:0] d, e;
        rd(3'd0, d);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
        if (d !== e) check("R6 data word", d, e);
        else vectors++;
    endtask

    task automatic issue(input logic [15:0] lim, input logic [7:0] feat);
        wr(3'd4, {8'd0, lim[7:0]});
        wr(3'd5, {8'd0, lim[15:8]});
        wr(3'd1, {8'd0, feat});
        wr(3'd7, 16'h00A0);
    endtask

    task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] cnt);
        logic [7:0] b [12];
        for (int i = 0; i < 12; i++) b[i] = 8'd0;
        b[0] = op;
        b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
        b[7] = cnt[15:8];  b[8] = cnt[7:0];
        for (int i = 0; i < 6; i++) wr(3'd0, {b[2*i+1], b[2*i]});
    endtask

    task automatic run_read(input logic [15:0] lim, input logic [31:0] lba, input int cnt);
        logic [15:0] s;
        int remaining, per, n;
        issue(lim, 8'd0);
        peek_status(s);
        check("R2 packet request status", s, 16'h0048);
        check("R2 no irq on packet request", {15'd0, irq}, 16'd0);
        send_pkt(8'h28, lba, cnt[15:0]);
        push_expect(lba, cnt);
        remaining = cnt * 1024;
        per = lim[15:1];
        while (remaining > 0) begin
            n = (remaining < per) ? remaining : per;
            wait_irq("R4 burst irq");
            rd(3'd7, s);
            check("R4 burst status", s, 16'h0048);
            check("R8 irq cleared by status read", {15'd0, irq}, 16'd0);
            for (int k = 0; k < n; k++) read_word();
            remaining -= n;
            if (remaining > 0) begin
                peek_status(s);
                check("R5 burst boundary status", s, 16'h00C0);
            end
        end
        wait_irq("R7 completion irq");
        rd(3'd7, s);
        check("R7 completion status", s, 16'h0040);
        check("R6 all words consumed", 16'(exp_q.size()), 16'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek_status(s);
        check("R1 reset status", s, 16'h0040);
        check("R1 reset irq", {15'd0, irq}, 16'd0);

        // R2 foreign command ignored
        wr(3'd7, 16'h00EC);
        repeat (2) @(negedge clk);
        peek_status(s);
        check("R2 foreign command status", s, 16'h0040);
        check("R2 foreign command irq", {15'd0, irq}, 16'd0);

        // R3 R6 single block at address 0
        run_read(16'd5120, 32'd0, 1);
        // R5 odd limit trimmed, multi-block, two bursts
        run_read(16'd5121, 32'd7, 5);
        // R5 non-dividing limit, block field wrap
        run_read(16'd3000, 32'h0000_003F, 2);

        // R9 limit zero
        issue(16'd0, 8'd0);
        wait_irq("R9 limit zero irq");
        rd(3'd7, s);
        check("R9 limit zero status", s, 16'h0041);
        // R9 limit one trims to zero
        issue(16'd1, 8'd0);
        wait_irq("R9 limit one irq");
        rd(3'd7, s);
        check("R9 limit one status", s, 16'h0041);

        // R11 DMA data phase requested
        issue(16'd5120, 8'd1);
        wait_irq("R11 dma irq");
        rd(3'd7, s);
        check("R11 dma status", s, 16'h0041);

        // R10 unsupported opcode; new command clears error first (R2)
        issue(16'd5120, 8'd0);
        peek_status(s);
        check("R2 error cleared by new command", s, 16'h0048);
        send_pkt(8'h12, 32'd0, 16'd1);
        wait_irq("R10 bad opcode irq");
        rd(3'd7, s);
        check("R10 bad opcode status", s, 16'h0041);

        // R12 zero block count
        issue(16'd5120, 8'd0);
        send_pkt(8'h28, 32'd4, 16'd0);
        wait_irq("R12 zero count irq");
        rd(3'd7, s);
        check("R12 zero count status", s, 16'h0040);
        check("R8 irq cleared after completion read", {15'd0, irq}, 16'd0);

        finish_run();
    end
endmodule